// File: doc/BRIEF.md
# Fan tachometer timer register file

This block is the bus-side register file of a two-channel fan tachometer timer. A simple strobe interface with address, data and access size reaches a small map of byte and halfword registers. Each register answers to exactly one access size. A wrong size, an odd offset or an unmapped offset gets an error response and changes nothing.

The block holds the configuration that the counting datapath reads: prescaler, clock select, mode control, compare configuration, two compare targets and two input selects. It also holds six interrupt pending flags, an enable mask for them and the two capture registers. The datapath lives outside the block. It sets pending flags through one-cycle set pulses and loads the capture registers through write strobes. Software writes to the count offsets become load strobes toward the datapath, and reads of those offsets return the datapath's live counts. A single registered level interrupt summarises the enabled pending flags.

Top module: `tach_regs`

## Requirements
- R1: Halfword registers sit at offsets 0x00 (count 1), 0x02 (capture A), 0x04 (capture B), 0x06 (count 2), 0x14 (compare target A) and 0x16 (compare target B). Each one accepts an access only when `half`=1.
- R2: Byte registers sit at offsets 0x08 (prescaler), 0x0A (clock select), 0x0C (mode), 0x0E (pending), 0x10 (clear), 0x12 (enable), 0x18 (compare config), 0x1A (input select A) and 0x1C (input select B). Each one accepts an access only when `half`=0, uses `wdata[7:0]`, and reads back with the upper byte zero.
- R3: An access at any other offset, or of the wrong size, raises `err` in the same cycle, returns `rdata`=0 and changes no register.
- R4: A byte write to the clear register drops every pending bit whose position holds a one in `wdata[5:0]`. Reads of the clear register return 0.
- R5: Pending bit i is set by `set_pend[i]`. The layout is: bit 0 capture A, bit 1 capture B, bit 2 underflow A, bit 3 underflow B, bit 4 compare hit A, bit 5 compare hit B. The enable register uses the same layout, and only bits 5:0 of both are stored. Bus writes to the pending register have no effect.
- R6: When a set pulse and a clear write target the same pending bit in one cycle, the bit ends up set.
- R7: `irq` is registered. It equals the OR of (pending AND enable) as it stood one clock earlier.
- R8: Reset clears the prescaler, clock select, mode, pending, enable, compare config, compare targets and input selects, and holds `irq` low. The capture registers keep their values through reset.
- R9: An accepted write to offset 0x00 or 0x06 pulses `ld_cnt1` or `ld_cnt2` in that cycle, with `ld_val`=`wdata`. Reads of those offsets return `cnt1_cur` or `cnt2_cur`.
- R10: `cap_a_we` or `cap_b_we` loads `cap_a_val` or `cap_b_val` into the matching capture register. A datapath load wins over a bus write in the same cycle.
- R11: The configuration outputs always show the current contents of their registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access strobe |
| wr | input | 1 | 1 = write, 0 = read |
| half | input | 1 | 1 = halfword access, 0 = byte access |
| addr | input | AW | Byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, same cycle |
| err | output | 1 | Access rejected, same cycle |
| set_pend | input | 6 | Pending set pulses from the datapath |
| cap_a_we | input | 1 | Capture A load strobe |
| cap_b_we | input | 1 | Capture B load strobe |
| cap_a_val | input | 16 | Capture A value |
| cap_b_val | input | 16 | Capture B value |
| cnt1_cur | input | 16 | Live count 1 |
| cnt2_cur | input | 16 | Live count 2 |
| ld_cnt1 | output | 1 | Count 1 load strobe |
| ld_cnt2 | output | 1 | Count 2 load strobe |
| ld_val | output | 16 | Count load value |
| prescale | output | 8 | Prescaler |
| clk_sel | output | 8 | Clock select |
| mode | output | 8 | Mode control |
| cmp_cfg | output | 8 | Compare configuration |
| in_sel_a | output | 8 | Input select A |
| in_sel_b | output | 8 | Input select B |
| cmp_a | output | 16 | Compare target A |
| cmp_b | output | 16 | Compare target B |
| irq | output | 1 | Level interrupt |

## Verification
A decode error shows up in the same cycle as a wrong `err` or `rdata` at the offending offset. A stray write that lands in the wrong register shows up on the configuration outputs one edge later. Errors in pending state, such as a lost set, an over-eager clear or a reversed set-versus-clear priority, show up on the next read of the pending offset. They also show up on `irq` one edge after the flag changes. Sweeping every offset with both sizes, every set and clear pair, and every pair of enable and pending patterns puts each of these faults on a port within two cycles of its cause.

// File: rtl/tach_regs.sv
module tach_regs #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic          half,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata,
  output logic          err,
  input  logic [5:0]    set_pend,
  input  logic          cap_a_we,
  input  logic          cap_b_we,
  input  logic [15:0]   cap_a_val,
  input  logic [15:0]   cap_b_val,
  input  logic [15:0]   cnt1_cur,
  input  logic [15:0]   cnt2_cur,
  output logic          ld_cnt1,
  output logic          ld_cnt2,
  output logic [15:0]   ld_val,
  output logic [7:0]    prescale,
  output logic [7:0]    clk_sel,
  output logic [7:0]    mode,
  output logic [7:0]    cmp_cfg,
  output logic [7:0]    in_sel_a,
  output logic [7:0]    in_sel_b,
  output logic [15:0]   cmp_a,
  output logic [15:0]   cmp_b,
  output logic          irq
);
  localparam logic [AW-1:0] O_CNT1 = AW'('h00), O_CAPA = AW'('h02), O_CAPB = AW'('h04),
                            O_CNT2 = AW'('h06), O_PRSC = AW'('h08), O_CSEL = AW'('h0A),
                            O_MODE = AW'('h0C), O_PEND = AW'('h0E), O_CLR  = AW'('h10),
                            O_IEN  = AW'('h12), O_CMPA = AW'('h14), O_CMPB = AW'('h16),
                            O_CCFG = AW'('h18), O_ISA  = AW'('h1A), O_ISB  = AW'('h1C);

  logic        is_hw, is_byte, ok, wen;
  logic [5:0]  pend, ien, clr;
  logic [15:0] cap_a, cap_b;

  always_comb begin
    is_hw   = 1'b0;
    is_byte = 1'b0;
    case (addr)
      O_CNT1, O_CAPA, O_CAPB, O_CNT2, O_CMPA, O_CMPB: is_hw = 1'b1;
      O_PRSC, O_CSEL, O_MODE, O_PEND, O_CLR, O_IEN,
      O_CCFG, O_ISA, O_ISB:                          is_byte = 1'b1;
      default: ;
    endcase
  end

  assign ok      = (is_hw && half) || (is_byte && !half);
  assign err     = req && !ok;
  assign wen     = req && wr && ok;
  assign ld_cnt1 = wen && addr == O_CNT1;
  assign ld_cnt2 = wen && addr == O_CNT2;
  assign ld_val  = wdata;
  assign clr     = (wen && addr == O_CLR) ? wdata[5:0] : 6'd0;

  always_comb begin
    rdata = 16'd0;
    if (req && ok && !wr) begin
      case (addr)
        O_CNT1: rdata = cnt1_cur;
        O_CAPA: rdata = cap_a;
        O_CAPB: rdata = cap_b;
        O_CNT2: rdata = cnt2_cur;
        O_CMPA: rdata = cmp_a;
        O_CMPB: rdata = cmp_b;
        O_PRSC: rdata = {8'd0, prescale};
        O_CSEL: rdata = {8'd0, clk_sel};
        O_MODE: rdata = {8'd0, mode};
        O_PEND: rdata = {10'd0, pend};
        O_IEN:  rdata = {10'd0, ien};
        O_CCFG: rdata = {8'd0, cmp_cfg};
        O_ISA:  rdata = {8'd0, in_sel_a};
        O_ISB:  rdata = {8'd0, in_sel_b};
        default: rdata = 16'd0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prescale <= '0; clk_sel <= '0; mode <= '0; cmp_cfg <= '0;
      in_sel_a <= '0; in_sel_b <= '0; cmp_a <= '0; cmp_b <= '0;
      ien <= '0; pend <= '0; irq <= 1'b0;
    end else begin
      if (wen) begin
        case (addr)
          O_PRSC: prescale <= wdata[7:0];
          O_CSEL: clk_sel  <= wdata[7:0];
          O_MODE: mode     <= wdata[7:0];
          O_CCFG: cmp_cfg  <= wdata[7:0];
          O_ISA:  in_sel_a <= wdata[7:0];
          O_ISB:  in_sel_b <= wdata[7:0];
          O_IEN:  ien      <= wdata[5:0];
          O_CMPA: cmp_a    <= wdata;
          O_CMPB: cmp_b    <= wdata;
          default: ;
        endcase
      end
      pend <= (pend & ~clr) | set_pend;
      irq  <= |(pend & ien);
    end
  end

  always_ff @(posedge clk) begin
    if (cap_a_we)                    cap_a <= cap_a_val;
    else if (wen && addr == O_CAPA)  cap_a <= wdata;
    if (cap_b_we)                    cap_b <= cap_b_val;
    else if (wen && addr == O_CAPB)  cap_b <= wdata;
  end
endmodule

// File: rtl/tach_regs_chk.sv
module tach_regs_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          wr,
  input logic          half,
  input logic [AW-1:0] addr,
  input logic [15:0]   wdata,
  input logic          err,
  input logic [5:0]    set_pend,
  input logic [5:0]    pend,
  input logic [5:0]    ien,
  input logic          ld_cnt1,
  input logic          ld_cnt2,
  input logic [7:0]    prescale,
  input logic          irq
);
  logic acc_ok_wr;
  assign acc_ok_wr = req && wr && !err && !half;

  p_odd_rejected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req && addr[0] |-> err);

  p_err_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req && wr && err |=> $stable(prescale));

  p_clear_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok_wr && addr == AW'('h10) |=> (pend & $past(wdata[5:0] & ~set_pend)) == 6'd0);

  p_pend_wr_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok_wr && addr == AW'('h0E) |=> pend == ($past(pend) | $past(set_pend)));

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    |set_pend |=> (pend & $past(set_pend)) == $past(set_pend));

  p_irq_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|(pend & ien)));

  p_irq_low_reset_r8: assert property (@(posedge clk)
    !rst_n |-> !irq);

  p_load_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_cnt1, ld_cnt2}));

  p_load_is_hw_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_cnt1 || ld_cnt2 |-> req && wr && half);
endmodule

bind tach_regs tach_regs_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .half(half), .addr(addr),
  .wdata(wdata), .err(err), .set_pend(set_pend), .pend(pend), .ien(ien),
  .ld_cnt1(ld_cnt1), .ld_cnt2(ld_cnt2), .prescale(prescale), .irq(irq)
);

// File: tb/tach_regs_tb.sv
module tach_regs_tb_top;
  localparam int AW = 12;
  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, wr = 1'b0, half = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic err;
  logic [5:0] set_pend = '0;
  logic cap_a_we = 1'b0, cap_b_we = 1'b0;
  logic [15:0] cap_a_val = '0, cap_b_val = '0;
  logic [15:0] cnt1_cur = 16'hA5C3, cnt2_cur = 16'h3C5A;
  logic ld_cnt1, ld_cnt2;
  logic [15:0] ld_val, cmp_a, cmp_b;
  logic [7:0] prescale, clk_sel, mode, cmp_cfg, in_sel_a, in_sel_b;
  logic irq;

  always #4 clk = ~clk;

  tach_regs #(.AW(AW)) dut_i (.*);

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [15:0] o_rd;
  logic o_err, o_ld1, o_ld2;
  logic [15:0] o_ldv;
  logic [15:0] model [32];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input int a, input logic h, input logic [15:0] d,
                     input logic [5:0] sp);
    @(negedge clk);
    req = 1'b1; wr = w; addr = AW'(a); half = h; wdata = d; set_pend = sp;
    #1;
    o_rd = rdata; o_err = err; o_ld1 = ld_cnt1; o_ld2 = ld_cnt2; o_ldv = ld_val;
    @(posedge clk); #1;
    req = 1'b0; wr = 1'b0; set_pend = '0;
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  function automatic logic exp_ok(input int a, input logic h);
    case (a)
      'h00, 'h02, 'h04, 'h06, 'h14, 'h16: return h;
      'h08, 'h0A, 'h0C, 'h0E, 'h10, 'h12, 'h18, 'h1A, 'h1C: return !h;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R8 irq in reset", irq, 0);
    chk("R8 prescale in reset", prescale, 0);
    rst_n = 1'b1;
    idle();

    @(negedge clk);
    cap_a_we = 1'b1; cap_b_we = 1'b1; cap_a_val = 16'h1234; cap_b_val = 16'hBEEF;
    @(posedge clk); #1;
    cap_a_we = 1'b0; cap_b_we = 1'b0;

    for (int a = 0; a < 32; a++) model[a] = 16'h0000;
    model['h00] = cnt1_cur; model['h06] = cnt2_cur;
    model['h02] = 16'h1234; model['h04] = 16'hBEEF;

    foreach (model[a]) begin
      if (exp_ok(a, 1'b0) && a != 'h0E && a != 'h10) begin
        logic [15:0] v = 16'((a * 7 + 3) & 8'hFF);
        if (a == 'h12) v = v & 16'h003F;
        acc(1'b1, a, 1'b0, 16'hEE00 | v, 6'd0);
        model[a] = v;
      end
    end
    acc(1'b1, 'h14, 1'b1, 16'hC0DE, 6'd0); model['h14] = 16'hC0DE;
    acc(1'b1, 'h16, 1'b1, 16'h0BAD, 6'd0); model['h16] = 16'h0BAD;
    acc(1'b1, 'h0E, 1'b0, 16'h003F, 6'd0);

    chk("R11 prescale", prescale, model['h08]);
    chk("R11 clk_sel", clk_sel, model['h0A]);
    chk("R11 mode", mode, model['h0C]);
    chk("R11 cmp_cfg", cmp_cfg, model['h18]);
    chk("R11 in_sel_a", in_sel_a, model['h1A]);
    chk("R11 in_sel_b", in_sel_b, model['h1C]);
    chk("R11 cmp_a", cmp_a, 16'hC0DE);
    chk("R11 cmp_b", cmp_b, 16'h0BAD);

    for (int a = 0; a < 32; a++) begin
      for (int h = 0; h < 2; h++) begin
        acc(1'b0, a, h[0], 16'h0, 6'd0);
        chk($sformatf("R1 R2 R3 err a=%0h h=%0d", a, h), o_err, !exp_ok(a, h[0]));
        chk($sformatf("R1 R2 R3 R4 R5 R9 rdata a=%0h h=%0d", a, h), o_rd,
            exp_ok(a, h[0]) ? model[a] : 16'h0);
      end
    end
    acc(1'b0, 'h100, 1'b1, 16'h0, 6'd0);
    chk("R3 far offset err", o_err, 1);

    acc(1'b1, 'h14, 1'b0, 16'h00FF, 6'd0);
    chk("R3 byte write to hw err", o_err, 1);
    chk("R3 cmp_a unchanged", cmp_a, 16'hC0DE);
    acc(1'b1, 'h08, 1'b1, 16'h0077, 6'd0);
    chk("R3 hw write to byte err", o_err, 1);
    chk("R3 prescale unchanged", prescale, model['h08]);
    acc(1'b1, 'h09, 1'b0, 16'h0077, 6'd0);
    chk("R3 odd write prescale unchanged", prescale, model['h08]);

    acc(1'b1, 'h00, 1'b1, 16'h4321, 6'd0);
    chk("R9 ld_cnt1", {o_ld1, o_ld2}, 2'b10);
    chk("R9 ld_val", o_ldv, 16'h4321);
    acc(1'b1, 'h06, 1'b1, 16'h8765, 6'd0);
    chk("R9 ld_cnt2", {o_ld1, o_ld2}, 2'b01);
    chk("R9 ld_val 2", o_ldv, 16'h8765);
    acc(1'b1, 'h00, 1'b0, 16'h4321, 6'd0);
    chk("R9 no load on byte", {o_ld1, o_ld2}, 2'b00);

    @(negedge clk);
    cap_a_we = 1'b1; cap_a_val = 16'h5555;
    req = 1'b1; wr = 1'b1; half = 1'b1; addr = AW'('h02); wdata = 16'hAAAA;
    @(posedge clk); #1;
    cap_a_we = 1'b0; req = 1'b0; wr = 1'b0;
    acc(1'b0, 'h02, 1'b1, 16'h0, 6'd0);
    chk("R10 capture wins", o_rd, 16'h5555);
    acc(1'b1, 'h04, 1'b1, 16'h7777, 6'd0);
    acc(1'b0, 'h04, 1'b1, 16'h0, 6'd0);
    chk("R10 bus write capture B", o_rd, 16'h7777);

    acc(1'b0, 'h0E, 1'b0, 16'h0, 6'h2A);
    acc(1'b1, 'h12, 1'b0, 16'h0002, 6'd0);
    rst_n = 1'b0;
    #1;
    chk("R8 irq low in reset", irq, 0);
    idle();
    rst_n = 1'b1;
    idle();
    chk("R8 prescale reset", prescale, 0);
    chk("R8 clk_sel reset", clk_sel, 0);
    chk("R8 mode reset", mode, 0);
    chk("R8 cmp_cfg reset", cmp_cfg, 0);
    chk("R8 in_sel reset", {in_sel_a, in_sel_b}, 0);
    chk("R8 cmp reset", {cmp_a, cmp_b}, 0);
    acc(1'b0, 'h0E, 1'b0, 16'h0, 6'd0);
    chk("R8 pend reset", o_rd, 0);
    acc(1'b0, 'h12, 1'b0, 16'h0, 6'd0);
    chk("R8 ien reset", o_rd, 0);
    acc(1'b0, 'h02, 1'b1, 16'h0, 6'd0);
    chk("R8 capture A kept", o_rd, 16'h5555);
    acc(1'b0, 'h04, 1'b1, 16'h0, 6'd0);
    chk("R8 capture B kept", o_rd, 16'h7777);

    for (int s = 0; s < 64; s++) begin
      for (int c = 0; c < 64; c++) begin
        acc(1'b0, 'h0E, 1'b0, 16'h0, 6'h3F);
        acc(1'b1, 'h10, 1'b0, 16'(c), 6'(s));
        acc(1'b0, 'h0E, 1'b0, 16'h0, 6'd0);
        chk($sformatf("R4 R6 pend s=%0h c=%0h", s, c), o_rd,
            16'((6'h3F & ~6'(c)) | 6'(s)));
      end
    end

    for (int e = 0; e < 64; e++) begin
      for (int k = 0; k < 3; k++) begin
        logic [5:0] p;
        p = (k == 0) ? 6'(e) : (k == 1) ? ~6'(e) : 6'(1 << (e % 6));
        acc(1'b1, 'h10, 1'b0, 16'h003F, 6'd0);
        acc(1'b1, 'h12, 1'b0, 16'(e), 6'd0);
        idle();
        acc(1'b0, 'h12, 1'b0, 16'h0, p);
        chk($sformatf("R7 irq latency e=%0h p=%0h", e, p), irq, 0);
        idle();
        chk($sformatf("R5 R7 irq e=%0h p=%0h", e, p), irq, |(p & 6'(e)));
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule